// File: doc/BRIEF.md
# Flash Control and Interrupt-Flag Register Unit

This block is a small special-function-register unit that sits beside an 8051-style processor core. It decodes an 8-bit register address on a simple read/write register bus and holds three registers. A flash control register decides where external-data move writes land: data RAM by default, or program flash when the program-write enable is set. The same register arms a mass erase and holds a security lock that can only be set. An interrupt-flag register latches two hardware events until software clears them. A read-only view shows the raw levels of seven external interrupt inputs.

Reads are combinational, and `bus_rdata` follows `bus_addr` in the same cycle. A write takes effect on the rising clock edge on which `bus_wr` is high. The flash programming sequencer is not part of this block. It is represented only by two pulse inputs: one for a finished flash byte and one for a finished mass erase. No signal carries a data stream, so every pin is a plain level or pulse and there is no back-pressure.

Top module: `flash_sfr_unit`

## Requirements
- R1: After reset, `prog_sel` is 0 (moves go to data RAM), `erase_arm` is 0, `secure_lock` is 0 and both `irq_flags` bits are 0. Writing bit 0 of address 0xB2 as 1 drives `prog_sel` to 1 (moves go to program flash) from the next cycle.
- R2: A `flash_byte_done` pulse clears the program-write enable on the following edge. If a write to 0xB2 occurs in the same cycle, the clear takes priority.
- R3: While `gie` is 1, writes to bit 0 of 0xB2 are ignored and the program-write enable keeps its value.
- R4: Bit 1 of 0xB2 is the mass-erase arm. It is write-only and always reads 0. Each write to 0xB2 loads it from bit 1 of the written byte. An `erase_done` pulse clears it, and the pulse wins over a write in the same cycle.
- R5: Bit 6 of 0xB2 is the security lock. Writing it as 1 sets it, and writing it as 0 is ignored. Only reset clears it.
- R6: A read of 0xB2 returns the live `preboot` level in bit 7, the lock in bit 6 and the program-write enable in bit 0. All other bits read 0.
- R7: At 0xE8, bit 0 is the transfer-busy flag and bit 1 is the 0.8-second tick flag. `xfer_evt` and `tick_evt` set them on the next edge. A read of 0xE8 returns the flags in bits 1:0 and zeros above them.
- R8: A write to 0xE8 clears each flag whose written bit is 0 and leaves each flag whose written bit is 1 unchanged. A hardware set in the same cycle wins over the clear.
- R9: A read of 0xF8 returns `ext_irq[6:0]` in bits 6:0, combinationally and without latching. Bit 7 reads 0.
- R10: Reads of any other address return 0, and writes to any other address change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| gie | input | 1 | Global interrupt enable from the core |
| preboot | input | 1 | Preboot sequence active |
| flash_byte_done | input | 1 | Pulse: one flash byte has been written |
| erase_done | input | 1 | Pulse: mass erase has finished |
| xfer_evt | input | 1 | Hardware event that sets the transfer-busy flag |
| tick_evt | input | 1 | Hardware event that sets the 0.8 s tick flag |
| ext_irq | input | 7 | Raw external interrupt input levels |
| prog_sel | output | 1 | 1: moves target program flash; 0: data RAM |
| erase_arm | output | 1 | Mass erase armed |
| secure_lock | output | 1 | Security lock |
| irq_flags | output | 2 | Latched flags {tick, transfer-busy} |

## Verification
Every piece of state is a single register bit that drives an output pin directly, so a wrong bit shows up at `prog_sel`, `erase_arm`, `secure_lock` or `irq_flags` one cycle after the edge that computed it. A lost lock, an ignored inhibit or a set-versus-clear race that resolves the wrong way is therefore visible on the next cycle. A wrong read layout or a wrong address decode shows up in `bus_rdata` in the same cycle that the address is presented, because no register sits in the read path.

// File: rtl/fsfr_pkg.sv
package fsfr_pkg;
  localparam int unsigned DW = 8;

  // bit positions inside the flash control byte
  localparam int unsigned PWE_POS = 0;
  localparam int unsigned ARM_POS = 1;
  localparam int unsigned SEC_POS = 6;
  localparam int unsigned PRE_POS = 7;

  typedef struct packed {
    logic secure;
    logic arm;
    logic pwe;
  } fctl_state_t;
endpackage

// File: rtl/fsfr_flash_ctl.sv
module fsfr_flash_ctl
  import fsfr_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic [W-1:0] wdata,
  input  logic         gie,
  input  logic         byte_done,
  input  logic         erase_done,
  output fctl_state_t  st
);
  fctl_state_t st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      // program-write enable: byte completion clears, gie inhibits writes
      if (byte_done)
        st_q.pwe <= 1'b0;
      else if (wr_hit && !gie)
        st_q.pwe <= wdata[PWE_POS];
      // erase arm: completion clears, any write reloads
      if (erase_done)
        st_q.arm <= 1'b0;
      else if (wr_hit)
        st_q.arm <= wdata[ARM_POS];
      // lock only accumulates ones
      if (wr_hit && wdata[SEC_POS])
        st_q.secure <= 1'b1;
    end
  end

  assign st = st_q;

  assert_pwe_autoclr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !st.pwe);
  assert_pwe_inhibit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && gie && !byte_done) |=> (st.pwe == $past(st.pwe)));
  assert_arm_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_done |=> !st.arm);
  assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st.secure |=> st.secure);
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && !byte_done && !erase_done) |=> $stable(st));
endmodule

// File: rtl/fsfr_irq_flags.sv
module fsfr_irq_flags #(
  parameter int unsigned NF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [NF-1:0] keep_mask,
  input  logic [NF-1:0] set_evt,
  output logic [NF-1:0] flags
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        f_q <= 1'b0;
      else if (set_evt[i])
        f_q <= 1'b1;
      else if (wr_hit && !keep_mask[i])
        f_q <= 1'b0;
    end
    assign flags[i] = f_q;

    assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[i] |=> flags[i]);
    assert_flag_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !(wr_hit && !keep_mask[i])) |=> flags[i]);
    assert_flag_noset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[i] && !set_evt[i]) |=> !flags[i]);
  end
endmodule

// File: rtl/fsfr_read_mux.sv
module fsfr_read_mux
  import fsfr_pkg::*;
#(
  parameter int unsigned    W      = DW,
  parameter int unsigned    NF     = 2,
  parameter int unsigned    NIRQ   = 7,
  parameter logic [W-1:0]   A_FCTL = 8'hB2,
  parameter logic [W-1:0]   A_FLAG = 8'hE8,
  parameter logic [W-1:0]   A_IRQ  = 8'hF8
) (
  input  logic [W-1:0]    addr,
  input  fctl_state_t     st,
  input  logic            preboot,
  input  logic [NF-1:0]   flags,
  input  logic [NIRQ-1:0] ext_irq,
  output logic [W-1:0]    rdata
);
  always_comb begin
    rdata = '0;
    unique case (addr)
      A_FCTL: begin
        rdata[PWE_POS] = st.pwe;
        rdata[SEC_POS] = st.secure;
        rdata[PRE_POS] = preboot;
      end
      A_FLAG:  rdata[NF-1:0]   = flags;
      A_IRQ:   rdata[NIRQ-1:0] = ext_irq;
      default: rdata = '0;
    endcase
  end

  always_comb begin
    if (addr == A_FCTL) assert_arm_hidden_R4: assert (rdata[ARM_POS] == 1'b0);
  end
endmodule

// File: rtl/flash_sfr_unit.sv
module flash_sfr_unit
  import fsfr_pkg::*;
#(
  parameter int unsigned    NIRQ   = 7,
  parameter logic [DW-1:0]  A_FCTL = 8'hB2,
  parameter logic [DW-1:0]  A_FLAG = 8'hE8,
  parameter logic [DW-1:0]  A_IRQ  = 8'hF8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            gie,
  input  logic            preboot,
  input  logic            flash_byte_done,
  input  logic            erase_done,
  input  logic            xfer_evt,
  input  logic            tick_evt,
  input  logic [NIRQ-1:0] ext_irq,
  output logic            prog_sel,
  output logic            erase_arm,
  output logic            secure_lock,
  output logic [1:0]      irq_flags
);
  localparam int unsigned NF = 2;

  logic        wr_fctl, wr_flag;
  fctl_state_t st;
  logic [NF-1:0] flags;

  assign wr_fctl = bus_wr && (bus_addr == A_FCTL);
  assign wr_flag = bus_wr && (bus_addr == A_FLAG);

  fsfr_flash_ctl #(.W(DW)) u_fctl (
    .clk, .rst_n,
    .wr_hit(wr_fctl), .wdata(bus_wdata), .gie,
    .byte_done(flash_byte_done), .erase_done, .st
  );

  fsfr_irq_flags #(.NF(NF)) u_flags (
    .clk, .rst_n,
    .wr_hit(wr_flag), .keep_mask(bus_wdata[NF-1:0]),
    .set_evt({tick_evt, xfer_evt}), .flags
  );

  fsfr_read_mux #(.W(DW), .NF(NF), .NIRQ(NIRQ),
                  .A_FCTL(A_FCTL), .A_FLAG(A_FLAG), .A_IRQ(A_IRQ)) u_rmux (
    .addr(bus_addr), .st, .preboot, .flags, .ext_irq, .rdata(bus_rdata)
  );

  assign prog_sel    = st.pwe;
  assign erase_arm   = st.arm;
  assign secure_lock = st.secure;
  assign irq_flags   = flags;

  assert_sel_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fctl && !gie && !flash_byte_done && bus_wdata[PWE_POS]) |=> prog_sel);
endmodule

// File: tb/test_flash_sfr_unit.sv
`timescale 1ns/1ps
module test_flash_sfr_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic       bus_wr = 0, gie = 0, preboot = 0, flash_byte_done = 0, erase_done = 0;
  logic       xfer_evt = 0, tick_evt = 0;
  logic [6:0] ext_irq = '0;
  logic       prog_sel, erase_arm, secure_lock;
  logic [1:0] irq_flags;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  // bench model of the architectural state
  logic m_pwe = 0, m_arm = 0, m_sec = 0;
  logic [1:0] m_flg = '0;

  always #2.5 clk = ~clk;

  flash_sfr_unit i_flash_sfr_unit (
    .clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_rdata,
    .gie, .preboot, .flash_byte_done, .erase_done, .xfer_evt, .tick_evt,
    .ext_irq, .prog_sel, .erase_arm, .secure_lock, .irq_flags
  );

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    case (a)
      8'hB2:   return {preboot, m_sec, 5'b0, m_pwe};   // R6, R4 arm reads 0
      8'hE8:   return {6'b0, m_flg};                   // R7
      8'hF8:   return {1'b0, ext_irq};                 // R9
      default: return 8'h00;                           // R10
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_state();
    chk("R1/R2/R3 prog_sel", {7'b0, prog_sel}, {7'b0, m_pwe});
    chk("R4 erase_arm", {7'b0, erase_arm}, {7'b0, m_arm});
    chk("R5 secure_lock", {7'b0, secure_lock}, {7'b0, m_sec});
    chk("R7/R8 irq_flags", {6'b0, irq_flags}, {6'b0, m_flg});
  endtask

  function automatic void model_edge();
    logic wf, we;
    logic [1:0] base;
    wf = bus_wr && bus_addr == 8'hB2;
    we = bus_wr && bus_addr == 8'hE8;
    if (flash_byte_done) m_pwe = 0; else if (wf && !gie) m_pwe = bus_wdata[0];
    if (erase_done) m_arm = 0; else if (wf) m_arm = bus_wdata[1];
    if (wf && bus_wdata[6]) m_sec = 1;
    base = we ? (m_flg & bus_wdata[1:0]) : m_flg;
    m_flg = base | {tick_evt, xfer_evt};
  endfunction

  task automatic step(input logic [7:0] a, input logic w, input logic [7:0] d,
                      input logic g, input logic bd, input logic ed,
                      input logic xe, input logic te);
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_wdata = d; gie = g;
    flash_byte_done = bd; erase_done = ed; xfer_evt = xe; tick_evt = te;
    #1;
    chk("R6/R7/R9/R10 read", bus_rdata, exp_read(a));
    @(posedge clk);
    model_edge();
    #1;
    check_state();
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20061));
    #12; rst_n = 1;
    @(negedge clk);
    check_state();                                      // R1 reset values
    chk("R1 reset read B2", bus_rdata, 8'h00);
    // R1: set pwe with interrupts off
    step(8'hB2, 1, 8'h01, 0, 0, 0, 0, 0);
    // R2: byte done clears it, with a simultaneous write losing
    step(8'hB2, 1, 8'h01, 0, 1, 0, 0, 0);
    // R3: write blocked while gie
    step(8'hB2, 1, 8'h01, 1, 0, 0, 0, 0);
    step(8'hB2, 1, 8'h01, 0, 0, 0, 0, 0);
    step(8'hB2, 1, 8'h00, 1, 0, 0, 0, 0);
    // R4: arm, read back as 0, done clears, rewrite needed
    step(8'hB2, 1, 8'h02, 0, 0, 0, 0, 0);
    step(8'hB2, 0, 8'h00, 0, 0, 0, 0, 0);
    step(8'hB2, 1, 8'h02, 0, 0, 1, 0, 0);
    // R10: unmapped write
    step(8'hB3, 1, 8'hFF, 0, 0, 0, 0, 0);
    // R5: set lock, try to clear
    step(8'hB2, 1, 8'h40, 0, 0, 0, 0, 0);
    step(8'hB2, 1, 8'h00, 0, 0, 0, 0, 0);
    // R6: preboot visible
    preboot = 1;
    step(8'hB2, 0, 8'h00, 0, 0, 0, 0, 0);
    // R7/R8: set both, clear only xfer, then set-vs-clear race
    step(8'hE8, 0, 8'h00, 0, 0, 0, 1, 1);
    step(8'hE8, 1, 8'hFE, 0, 0, 0, 0, 0);
    step(8'hE8, 1, 8'hFC, 0, 0, 0, 0, 1);
    step(8'hE8, 1, 8'h00, 0, 0, 0, 0, 0);
    // R9: live irq view
    ext_irq = 7'h55;
    step(8'hF8, 1, 8'h00, 0, 0, 0, 0, 0);
    // random phase
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] a;
      case ($urandom % 4)
        0: a = 8'hB2;
        1: a = 8'hE8;
        2: a = 8'hF8;
        default: a = 8'($urandom);
      endcase
      preboot = 1'($urandom);
      ext_irq = 7'($urandom);
      step(a, 1'($urandom), 8'($urandom), 1'($urandom),
           ($urandom % 6) == 0, ($urandom % 8) == 0,
           ($urandom % 5) == 0, ($urandom % 5) == 0);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule